// File: doc/BRIEF.md
# Serial Programming Target Emulator

This block answers as the target side of a byte-serial in-system programming link. A host programmer clocks bytes in over SPI mode 0 (clock idle low, data sampled on the rising clock edge, active-low select). The block groups those bytes into four-byte command frames. It decodes four commands against an internal 1024-byte RAM that stands in for program flash: erase everything, read one byte, write one byte, and read one identification byte. When a command produces data, that byte goes back to the host on MISO during the fourth byte of the same frame.

The serial clock, select and data input are synchronised into the system clock domain. The system clock must run at least four times faster than the serial clock. The frame sequencer is a five-state machine:

- `S_B1`, `S_B2`, `S_B3` and `S_B4` mark which byte of the frame comes next. Each completed byte moves the machine one step along `S_B1 -> S_B2 -> S_B3 -> S_B4 -> S_B1`.
- On the third byte of an erase frame, the machine takes `S_B3 -> S_ERASE` instead.
- `S_ERASE` writes 0xFF into one location per cycle. After the last location it takes `S_ERASE -> S_B1`.
- A falling select edge forces any state other than `S_ERASE` back to `S_B1`.

Top module: `isp_target_emu`

## Requirements
- R1: A falling edge on `spi_cs_n` restarts framing outside an erase, so the next byte received is treated as byte 1 of a new frame, whatever partial frame came before.
- R2: With select held low, the byte after a frame's fourth byte is byte 1 of the next frame, so frames may follow each other without releasing select.
- R3: When byte 3 arrives with byte 1 equal to 0xAC and bits 7:5 of byte 2 equal to 3'b100, every memory location becomes 0xFF. `busy` is high while this runs, and it takes at most 1024 system clock cycles.
- R4: When byte 3 arrives with (byte 1 & 0xF7) equal to 0x20, the memory byte at address {byte2[0], byte3, byte1[3]} is returned MSB first on MISO during byte 4. Bit 3 of byte 1 set means the high byte of the word; clear means the low byte.
- R5: When byte 4 arrives with (byte 1 & 0xF7) equal to 0x40, byte 4 is stored at address {byte2[0], byte3, byte1[3]}.
- R6: When byte 3 arrives with byte 1 equal to 0x30, byte 4 returns entry byte3[1:0] of the identification table {0x1E, 0x90, 0x05, 0x00}. Indices above 3 wrap.
- R7: MISO carries 0x00 in every byte slot except byte 4 of a read or identification frame. A frame that matches no command leaves the memory unchanged.
- R8: While `busy` is high, received bytes are ignored and change neither memory nor MISO. Once it clears, decoding resumes at byte 1.
- R9: Bits 7:1 of byte 2 have no effect on the address used by reads and writes.
- R10: MISO changes only after a falling serial clock edge (or a select fall) and holds steady while the serial clock is high.
- R11: An erase is recognised whatever bits 4:0 of byte 2 hold. A frame with byte 1 = 0xAC but byte 2 bits 7:5 other than 3'b100 is treated as unmatched.
- R12: After reset, `busy` is low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while the erase sweep runs |

## Verification
The bench targets the byte-slot alignment of responses. A reply loaded one byte too late, or not at a byte boundary, shows up as a shifted value on every read and identification frame. It also checks the address packing at its extremes (word 0x1FF high byte, and byte 2 carrying noise in its upper bits), because a swapped select bit or a wide byte-2 field would land writes and reads on different locations. Select is dropped in the middle of a frame, and frames are run back to back under one select; a design that failed to resynchronise would take the next command byte as data. Bytes are also sent during an erase, and two near-miss erase codes are tried. A decoder that let bytes through during the sweep, or that masked too few or too many erase bits, would leave stray data behind or wipe memory by mistake.

// File: rtl/isp_emu_pkg.sv
`timescale 1ns/1ps
package isp_emu_pkg;

    typedef enum logic [2:0] {
        S_B1,
        S_B2,
        S_B3,
        S_B4,
        S_ERASE
    } frame_state_t;

    localparam logic [7:0] OP_ERASE  = 8'hAC;
    localparam logic [2:0] ERASE_TAG = 3'b100;
    localparam logic [7:0] OP_READ   = 8'h20;
    localparam logic [7:0] OP_WRITE  = 8'h40;
    localparam logic [7:0] OP_IDENT  = 8'h30;
    localparam logic [7:0] HILO_MASK = 8'hF7;
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    function automatic logic [7:0] ident_byte(input logic [1:0] idx);
        logic [7:0] v;
        unique case (idx)
            2'd0: v = 8'h1E;
            2'd1: v = 8'h90;
            2'd2: v = 8'h05;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/isp_spi_shift.sv
`timescale 1ns/1ps
module isp_spi_shift #(
    parameter int BYTE_BITS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 spi_sck,
    input  logic                 spi_cs_n,
    input  logic                 spi_mosi,
    input  logic [BYTE_BITS-1:0] tx_byte,
    output logic                 spi_miso,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 byte_done,
    output logic                 cs_start
);
    localparam int CNT_W = $clog2(BYTE_BITS);
    localparam int SH_W  = SYNC_STAGES + 1;

    logic [SH_W-1:0]        sck_q, cs_q;
    logic [SYNC_STAGES-1:0] mosi_q;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_BITS-1:0]   tx_sh;
    logic                   rise, fall, cs_act;

    // synchronisers; the extra stage on sck/cs gives edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[SH_W-2:0], spi_sck};
            cs_q   <= {cs_q[SH_W-2:0], spi_cs_n};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], spi_mosi};
        end
    end

    assign rise     = sck_q[SH_W-2] & ~sck_q[SH_W-1];
    assign fall     = ~sck_q[SH_W-2] & sck_q[SH_W-1];
    assign cs_act   = ~cs_q[SH_W-2];
    assign cs_start = cs_q[SH_W-1] & ~cs_q[SH_W-2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_byte   <= '0;
            tx_sh     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (cs_start) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else if (cs_act) begin
                if (rise) begin
                    rx_byte <= {rx_byte[BYTE_BITS-2:0], mosi_q[SYNC_STAGES-1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(BYTE_BITS - 1)) begin
                        byte_done <= 1'b1;
                    end
                end
                if (fall) begin
                    if (bit_cnt == '0) begin
                        tx_sh <= tx_byte;
                    end else begin
                        tx_sh <= {tx_sh[BYTE_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign spi_miso = tx_sh[BYTE_BITS-1];

    // R10: the output bit moves only on a detected falling edge or select start
    a_r10_miso_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_start) |=> $stable(spi_miso));

    // R10: a byte completes only one cycle after a detected rising edge
    a_r10_byte_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(rise));

endmodule

// File: rtl/isp_flash_ram.sv
`timescale 1ns/1ps
module isp_flash_ram #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/isp_frame_ctrl.sv
`timescale 1ns/1ps
module isp_frame_ctrl
    import isp_emu_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    localparam int AW = $clog2(MEM_BYTES),
    localparam int FULL_AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_done,
    input  logic [7:0]    rx_byte,
    input  logic          cs_start,
    input  logic [7:0]    rd_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [7:0]    tx_byte,
    output logic          busy
);
    frame_state_t state, next_state;

    logic [7:0]         cmd_q;
    logic [2:0]         tag_q;
    logic               wmsb_q;
    logic [7:0]         wlow_q;
    logic [AW-1:0]      erase_cnt;
    logic               erase_last;
    logic               is_erase, is_read, is_write, is_ident;
    logic [FULL_AW-1:0] addr_b3, addr_b4;
    logic [7:0]         resp;

    assign is_erase   = (cmd_q == OP_ERASE) && (tag_q == ERASE_TAG);
    assign is_read    = (cmd_q & HILO_MASK) == OP_READ;
    assign is_write   = (cmd_q & HILO_MASK) == OP_WRITE;
    assign is_ident   = cmd_q == OP_IDENT;
    assign addr_b3    = {wmsb_q, rx_byte, cmd_q[3]};
    assign addr_b4    = {wmsb_q, wlow_q, cmd_q[3]};
    assign erase_last = erase_cnt == AW'(MEM_BYTES - 1);

    // next-state logic
    always_comb begin
        next_state = state;
        unique case (state)
            S_B1: if (byte_done) next_state = S_B2;
            S_B2: if (byte_done) next_state = S_B3;
            S_B3: if (byte_done) next_state = is_erase ? S_ERASE : S_B4;
            S_B4: if (byte_done) next_state = S_B1;
            S_ERASE: if (erase_last) next_state = S_B1;
            default: next_state = S_B1;
        endcase
        if (cs_start && state != S_ERASE) begin
            next_state = S_B1;
        end
    end

    // state register and frame capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_B1;
            cmd_q     <= '0;
            tag_q     <= '0;
            wmsb_q    <= 1'b0;
            wlow_q    <= '0;
            erase_cnt <= '0;
            tx_byte   <= '0;
        end else begin
            state <= next_state;
            if (state == S_ERASE) begin
                erase_cnt <= erase_last ? '0 : erase_cnt + 1'b1;
            end else if (cs_start) begin
                tx_byte <= '0;
            end else if (byte_done) begin
                tx_byte <= resp;
                unique case (state)
                    S_B1: cmd_q <= rx_byte;
                    S_B2: begin
                        tag_q  <= rx_byte[7:5];
                        wmsb_q <= rx_byte[0];
                    end
                    S_B3: wlow_q <= rx_byte;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = rx_byte;
        mem_addr  = addr_b4[AW-1:0];
        resp      = 8'h00;
        busy      = 1'b0;
        unique case (state)
            S_ERASE: begin
                busy      = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = FILL_BYTE;
                mem_addr  = erase_cnt;
            end
            S_B3: begin
                mem_addr = addr_b3[AW-1:0];
                if (is_read) begin
                    resp = rd_data;
                end else if (is_ident) begin
                    resp = ident_byte(rx_byte[1:0]);
                end
            end
            S_B4: mem_we = byte_done && is_write;
            default: ;
        endcase
    end

    // R1: a select fall outside the erase sweep realigns to byte 1
    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_start && state != S_ERASE) |=> (state == S_B1));

    // R2: the fourth byte wraps the frame back to byte 1
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_B4 && byte_done) |=> (state == S_B1));

    // R3: the sweep visits consecutive locations
    a_r3_sweep_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE && !erase_last) |=> (erase_cnt == $past(erase_cnt) + 1'b1));

    // R8: nothing reaches the reply path while busy
    a_r8_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ERASE) |=> $stable(tx_byte));

endmodule

// File: rtl/isp_target_emu.sv
`timescale 1ns/1ps
module isp_target_emu #(
    parameter int MEM_BYTES = 1024,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic busy
);
    logic [7:0]    rx_byte, tx_byte, rd_data, mem_wdata;
    logic          byte_done, cs_start, mem_we;
    logic [AW-1:0] mem_addr;

    isp_spi_shift #(.BYTE_BITS(8), .SYNC_STAGES(2)) u_shift (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .tx_byte(tx_byte), .spi_miso(spi_miso),
        .rx_byte(rx_byte), .byte_done(byte_done), .cs_start(cs_start)
    );

    isp_frame_ctrl #(.MEM_BYTES(MEM_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
        .cs_start(cs_start), .rd_data(rd_data), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .tx_byte(tx_byte),
        .busy(busy)
    );

    isp_flash_ram #(.DEPTH(MEM_BYTES), .WIDTH(8)) u_ram (
        .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
        .rdata(rd_data)
    );

endmodule

// File: tb/tb_isp_target_emu.sv
`timescale 1ns/1ps
module tb_isp_target_emu;
    logic clk = 1'b0;
    logic rst_n, sck, cs_n, mosi;
    logic miso, busy;
    int   checks = 0;
    int   errors = 0;
    int   hold_err = 0;
    logic [7:0] model [1024];

    always #5 clk = ~clk;

    isp_target_emu dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .busy(busy)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] i);
        for (int k = 7; k >= 0; k--) begin
            mosi = o[k];
            #40;
            sck = 1'b1;
            i[k] = miso;
            #20;
            if (miso !== i[k]) hold_err++;
            #20;
            sck = 1'b0;
        end
    endtask

    task automatic frame(input logic [7:0] b1, b2, b3, b4, output logic [31:0] r);
        logic [7:0] t;
        cs_n = 1'b0;
        #40;
        xfer(b1, t); r[31:24] = t;
        xfer(b2, t); r[23:16] = t;
        xfer(b3, t); r[15:8]  = t;
        xfer(b4, t); r[7:0]   = t;
        #40;
        cs_n = 1'b1;
        #80;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy === 1'b1 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk("R3 erase finished", {7'd0, busy}, 8'h00);
    endtask

    function automatic int baddr(input logic hi, input logic [8:0] w);
        return int'({w, hi});
    endfunction

    task automatic rd(input string req, input logic hi, input logic [8:0] w, input logic [6:0] noise);
        logic [31:0] r;
        frame(8'h20 | {4'd0, hi, 3'd0}, {noise, w[8]}, w[7:0], 8'h00, r);
        chk(req, r[7:0], model[baddr(hi, w)]);
        chk("R7 leading slots zero", r[31:24] | r[23:16] | r[15:8], 8'h00);
    endtask

    task automatic wr(input logic hi, input logic [8:0] w, input logic [6:0] noise, input logic [7:0] d);
        logic [31:0] r;
        frame(8'h40 | {4'd0, hi, 3'd0}, {noise, w[8]}, w[7:0], d, r);
        model[baddr(hi, w)] = d;
        chk("R7 write frame returns zero", r[7:0], 8'h00);
    endtask

    task automatic t_reset();
        chk("R12 busy after reset", {7'd0, busy}, 8'h00);
        chk("R12 miso after reset", {7'd0, miso}, 8'h00);
    endtask

    task automatic t_erase();
        logic [31:0] r;
        frame(8'hAC, 8'h80, 8'h00, 8'h00, r);
        chk("R3 busy during erase", {7'd0, busy}, 8'h01);
        wait_idle();
        for (int a = 0; a < 1024; a++) model[a] = 8'hFF;
        rd("R3 erased word 0 low", 1'b0, 9'h000, 7'd0);
        rd("R3 erased top byte", 1'b1, 9'h1FF, 7'd0);
        rd("R3 erased middle", 1'b1, 9'h0AA, 7'd0);
    endtask

    task automatic t_write_read();
        wr(1'b0, 9'h000, 7'd0, 8'h12);
        wr(1'b1, 9'h000, 7'd0, 8'h34);
        wr(1'b1, 9'h1FF, 7'h55, 8'hA5);
        wr(1'b0, 9'h1FF, 7'd0, 8'h5A);
        wr(1'b0, 9'h0AB, 7'h7F, 8'h77);
        rd("R4 low byte word 0", 1'b0, 9'h000, 7'd0);
        rd("R4 high byte word 0", 1'b1, 9'h000, 7'd0);
        rd("R5 top high byte", 1'b1, 9'h1FF, 7'd0);
        rd("R9 noisy byte2 read", 1'b0, 9'h1FF, 7'h3C);
        rd("R9 noisy byte2 write", 1'b0, 9'h0AB, 7'd0);
        rd("R4 neighbour untouched", 1'b1, 9'h0AB, 7'd0);
    endtask

    task automatic t_ident();
        logic [31:0] r;
        logic [7:0] tbl [4] = '{8'h1E, 8'h90, 8'h05, 8'h00};
        for (int i = 0; i < 8; i++) begin
            frame(8'h30, 8'h00, 8'(i), 8'h00, r);
            chk($sformatf("R6 ident index %0d", i), r[7:0], tbl[i % 4]);
        end
    endtask

    task automatic t_unmatched();
        logic [31:0] r;
        frame(8'h50, 8'h00, 8'h00, 8'h99, r);
        chk("R7 unmatched reply", r[7:0], 8'h00);
        chk("R7 unmatched early slots", r[31:24] | r[23:16] | r[15:8], 8'h00);
        frame(8'hAC, 8'hA0, 8'h00, 8'h00, r);
        chk("R11 near-miss erase not busy", {7'd0, busy}, 8'h00);
        frame(8'hAC, 8'h00, 8'h00, 8'h00, r);
        chk("R11 second near-miss not busy", {7'd0, busy}, 8'h00);
        rd("R7 memory kept word 0", 1'b0, 9'h000, 7'd0);
        rd("R11 memory kept top", 1'b1, 9'h1FF, 7'd0);
    endtask

    task automatic t_back_to_back();
        logic [7:0] t;
        cs_n = 1'b0;
        #40;
        xfer(8'h48, t); xfer(8'h00, t); xfer(8'h10, t); xfer(8'hC3, t);
        model[baddr(1'b1, 9'h010)] = 8'hC3;
        xfer(8'h28, t); xfer(8'h00, t); xfer(8'h10, t); xfer(8'h00, t);
        chk("R2 second frame read", t, 8'hC3);
        xfer(8'h30, t); xfer(8'h00, t); xfer(8'h01, t); xfer(8'h00, t);
        chk("R2 third frame ident", t, 8'h90);
        #40;
        cs_n = 1'b1;
        #80;
    endtask

    task automatic t_restart();
        logic [7:0] t;
        logic [31:0] r;
        cs_n = 1'b0;
        #40;
        xfer(8'h40, t); xfer(8'h00, t); xfer(8'h05, t);
        #40;
        cs_n = 1'b1;
        #80;
        frame(8'h30, 8'h00, 8'h02, 8'h00, r);
        chk("R1 realigned after select", r[7:0], 8'h05);
        rd("R1 partial frame no write", 1'b0, 9'h005, 7'd0);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] t;
        logic [31:0] r;
        cs_n = 1'b0;
        #40;
        xfer(8'hAC, t); xfer(8'h9F, t); xfer(8'h00, t);
        xfer(8'h40, t); xfer(8'h00, t); xfer(8'h07, t); xfer(8'h66, t);
        chk("R8 reply silent while busy", t, 8'h00);
        #40;
        cs_n = 1'b1;
        #80;
        chk("R11 erase with low bits set", {7'd0, busy}, 8'h01);
        wait_idle();
        for (int a = 0; a < 1024; a++) model[a] = 8'hFF;
        rd("R8 write during erase ignored", 1'b0, 9'h007, 7'd0);
        frame(8'h30, 8'h00, 8'h00, 8'h00, r);
        chk("R8 decoding resumes", r[7:0], 8'h1E);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sck   = 1'b0;
        cs_n  = 1'b1;
        mosi  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_erase();
        t_write_read();
        t_ident();
        t_unmatched();
        t_back_to_back();
        t_restart();
        t_busy_ignore();
        chk("R10 miso steady while sck high", 8'(hold_err), 8'h00);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule